// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block controls one switchable power domain. Software programs it through a small register window. One control word carries the collapse request, a hardware-trigger select, a sequencer bypass and three wait exponents. A second word carries two retention enables. The block sees a power-off or power-on request and walks the domain through a fixed order of steps. The clocks are gated, the clamp and domain reset are asserted and the switches are opened on the way down. The same steps run in reverse on the way up. Each wait lasts a power-of-two number of reference-oscillator ticks, and `ref_tick` marks those ticks.

The state machine has seven states:
- `ST_OFF`: collapsed.
- `ST_UP_FEW`: first switch group closed.
- `ST_UP_REST`: remaining switches closed.
- `ST_UP_REL`: clamp and reset released, clocks still held.
- `ST_ON`: clocks running.
- `ST_DN_CLK`: clocks gated.
- `ST_DN_ISO`: clamp and reset asserted.

The transitions are:
- start-up: `ST_OFF`→`ST_UP_FEW`, when the request says on.
- few-done: `ST_UP_FEW`→`ST_UP_REST`.
- rest-done: `ST_UP_REST`→`ST_UP_REL`.
- hold-done: `ST_UP_REL`→`ST_ON`.
- shut-down: `ST_ON`→`ST_DN_CLK`, when the request says off.
- gate-done: `ST_DN_CLK`→`ST_DN_ISO`.
- iso-done: `ST_DN_ISO`→`ST_OFF`.
- bypass: any state→`ST_ON` or `ST_OFF`, directly from the request, while the bypass bit is set.

A status bit tells software that the domain is really up. It follows the on state through a fixed delay line of reference ticks. The hardware-trigger mode lets an external request line replace the software bit.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, both switch groups are off, clamp and domain reset are asserted, and clocks are gated. The control word (address 0) reads 0x00282001: collapse=1, rest exponent 2, few exponent 8, clock-disable exponent 2, status 0. The retention word (address 1) reads 0.
- R2: The control word layout is:
  - bit 0: collapse request, 1 = off.
  - bit 1: hardware-trigger select.
  - bit 2: bypass.
  - bits 15:12: clock-disable exponent.
  - bits 19:16: few exponent.
  - bits 23:20: rest exponent.
  - bit 31: read-only status.
  - All other bits read 0, so writing all ones reads back 0x00FFF007 while the domain is off.
- R3: Power-up runs in this order:
  - The first switch group is on alone for 2^few ticks.
  - Both groups are on with the clamp still set for 2^rest ticks.
  - Clamp and reset are released, and the clocks stay gated for 4 more ticks.
  - The clocks are then enabled.
  - The rest group is never on without the few group, and the clocks never run while the clamp or reset is set or the switches are off.
- R4: Power-down runs in this order:
  - The clocks are gated for 2^clkdis ticks with the switches still on.
  - Clamp and reset are asserted for 1 tick.
  - Both switch groups open together.
- R5: The status bit rises 8 ticks after the clocks are enabled and falls 8 ticks after they are gated. Until then it keeps its previous value.
- R6: With hardware-trigger select set, the input `hw_collapse_req` (1 = off) chooses the direction and the software collapse bit has no effect.
- R7: With bypass set, the outputs take the full-on or full-off pattern one clock after the register holds the request, with no timed steps.
- R8: A request that changes during a sequence is not acted on until `ST_ON` or `ST_OFF` is reached. The request level seen there then decides the next sequence.
- R9: Retention word bit 14 drives `retain_mem` and bit 13 drives `retain_periph`. Both are plain read/write bits, and writes to the control word leave them unchanged.
- R10: Waits count only cycles with `ref_tick` high. With `ref_tick` held low, the sequencer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference-oscillator period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control, 1 retention |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| hw_collapse_req | input | 1 | External request in hardware-trigger mode, 1 = off |
| sw_few_en | output | 1 | Enable of the first switch group |
| sw_rest_en | output | 1 | Enable of the remaining switches |
| dom_clamp | output | 1 | Output clamp of the domain |
| dom_rst | output | 1 | Domain reset |
| dom_clk_en | output | 1 | Domain clock enable |
| pwr_on_status | output | 1 | Delayed power-on status (also control bit 31) |
| retain_mem | output | 1 | Memory retention enable |
| retain_periph | output | 1 | Peripheral retention enable |

## Verification
The case where two functions meet in one cycle is a new collapse request landing while a wait counter is expiring inside a power-up sequence. The bench provokes it by writing the opposite request one or two cycles into the few-switch phase. The request then reaches the state machine while it is still stepping. The bench also runs a request reversal inside the same sequence. It judges the result at the pins: the up sequence must still reach clock enable, and then the down steps must follow in order. For the reversed request, the domain must stay on with the status set.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_FEW,
        ST_UP_REST,
        ST_UP_REL,
        ST_ON,
        ST_DN_CLK,
        ST_DN_ISO
    } pds_state_e;

    typedef struct packed {
        logic few;
        logic rest;
        logic clamp;
        logic rst;
        logic clk_en;
    } pds_drive_t;

endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [WAIT_W-1:0] exp_n,
    output logic              done
);
    localparam int CW = 1 << WAIT_W;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = (CW'(1) << exp_n) - CW'(1);
    assign done = run && tick && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pds_status_pipe.sv
module pds_status_pipe #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic on_now,
    output logic status
);
    generate
        if (DLY == 1) begin : g_single
            logic stage;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage <= 1'b0;
                end else if (tick) begin
                    stage <= on_now;
                end
            end
            assign status = stage;
        end else begin : g_chain
            logic [DLY-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else if (tick) begin
                    chain <= {chain[DLY-2:0], on_now};
                end
            end
            assign status = chain[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/pds_regs.sv
module pds_regs #(
    parameter int WAIT_W   = 4,
    parameter int DEF_REST = 2,
    parameter int DEF_FEW  = 8,
    parameter int DEF_CLK  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              addr,
    input  logic [31:0]       wdata,
    input  logic              status_in,
    output logic [31:0]       rdata,
    output logic              collapse,
    output logic              hw_mode,
    output logic              bypass,
    output logic [WAIT_W-1:0] w_rest,
    output logic [WAIT_W-1:0] w_few,
    output logic [WAIT_W-1:0] w_clk,
    output logic              ret_mem,
    output logic              ret_per
);
    localparam int COLL_BIT = 0;
    localparam int HW_BIT   = 1;
    localparam int BYP_BIT  = 2;
    localparam int CLK_LSB  = 12;
    localparam int FEW_LSB  = CLK_LSB + WAIT_W;
    localparam int REST_LSB = FEW_LSB + WAIT_W;
    localparam int STAT_BIT = 31;
    localparam int RMEM_BIT = 14;
    localparam int RPER_BIT = 13;

    logic ctrl_we;
    logic ret_we;
    assign ctrl_we = we && !addr;
    assign ret_we  = we && addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collapse <= 1'b1;
            hw_mode  <= 1'b0;
            bypass   <= 1'b0;
            w_rest   <= WAIT_W'(DEF_REST);
            w_few    <= WAIT_W'(DEF_FEW);
            w_clk    <= WAIT_W'(DEF_CLK);
        end else if (ctrl_we) begin
            collapse <= wdata[COLL_BIT];
            hw_mode  <= wdata[HW_BIT];
            bypass   <= wdata[BYP_BIT];
            w_rest   <= wdata[REST_LSB +: WAIT_W];
            w_few    <= wdata[FEW_LSB +: WAIT_W];
            w_clk    <= wdata[CLK_LSB +: WAIT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_mem <= 1'b0;
            ret_per <= 1'b0;
        end else if (ret_we) begin
            ret_mem <= wdata[RMEM_BIT];
            ret_per <= wdata[RPER_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[COLL_BIT]                = collapse;
            rdata[HW_BIT]                  = hw_mode;
            rdata[BYP_BIT]                 = bypass;
            rdata[CLK_LSB +: WAIT_W]       = w_clk;
            rdata[FEW_LSB +: WAIT_W]       = w_few;
            rdata[REST_LSB +: WAIT_W]      = w_rest;
            rdata[STAT_BIT]                = status_in;
        end else begin
            rdata[RMEM_BIT] = ret_mem;
            rdata[RPER_BIT] = ret_per;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:REST_LSB+WAIT_W], wdata[CLK_LSB-1:BYP_BIT+1]};
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int WAIT_W    = 4,
    parameter int HOLD_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              collapse_req,
    input  logic              bypass,
    input  logic [WAIT_W-1:0] w_rest,
    input  logic [WAIT_W-1:0] w_few,
    input  logic [WAIT_W-1:0] w_clk,
    output pds_drive_t        drive,
    output logic              on_now
);
    localparam logic [WAIT_W-1:0] HOLD_EXP = WAIT_W'(HOLD_LOG2);

    pds_state_e        state_q;
    pds_state_e        state_d;
    logic              tmr_run;
    logic [WAIT_W-1:0] tmr_exp;
    logic              tmr_done;

    pds_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (tick),
        .exp_n (tmr_exp),
        .done  (tmr_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer selection: which wait is active in which state.
    always_comb begin
        tmr_run = 1'b0;
        tmr_exp = '0;
        if (!bypass) begin
            unique case (state_q)
                ST_UP_FEW:  begin tmr_run = 1'b1; tmr_exp = w_few;    end
                ST_UP_REST: begin tmr_run = 1'b1; tmr_exp = w_rest;   end
                ST_UP_REL:  begin tmr_run = 1'b1; tmr_exp = HOLD_EXP; end
                ST_DN_CLK:  begin tmr_run = 1'b1; tmr_exp = w_clk;    end
                ST_DN_ISO:  begin tmr_run = 1'b1; tmr_exp = '0;       end
                default:    begin tmr_run = 1'b0; tmr_exp = '0;       end
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (bypass) begin
            state_d = collapse_req ? ST_OFF : ST_ON;
        end else begin
            unique case (state_q)
                ST_OFF:     if (!collapse_req) state_d = ST_UP_FEW;
                ST_UP_FEW:  if (tmr_done)      state_d = ST_UP_REST;
                ST_UP_REST: if (tmr_done)      state_d = ST_UP_REL;
                ST_UP_REL:  if (tmr_done)      state_d = ST_ON;
                ST_ON:      if (collapse_req)  state_d = ST_DN_CLK;
                ST_DN_CLK:  if (tmr_done)      state_d = ST_DN_ISO;
                ST_DN_ISO:  if (tmr_done)      state_d = ST_OFF;
                default:                       state_d = ST_OFF;
            endcase
        end
    end

    // Output decode per state.
    always_comb begin
        drive = '{few: 1'b0, rest: 1'b0, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
        unique case (state_q)
            ST_OFF:     drive = '{few: 1'b0, rest: 1'b0, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
            ST_UP_FEW:  drive = '{few: 1'b1, rest: 1'b0, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
            ST_UP_REST: drive = '{few: 1'b1, rest: 1'b1, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
            ST_UP_REL:  drive = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0, clk_en: 1'b0};
            ST_ON:      drive = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0, clk_en: 1'b1};
            ST_DN_CLK:  drive = '{few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0, clk_en: 1'b0};
            ST_DN_ISO:  drive = '{few: 1'b1, rest: 1'b1, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
            default:    drive = '{few: 1'b0, rest: 1'b0, clamp: 1'b1, rst: 1'b1, clk_en: 1'b0};
        endcase
    end

    assign on_now = (state_q == ST_ON);
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int WAIT_W    = 4,
    parameter int DEF_REST  = 2,
    parameter int DEF_FEW   = 8,
    parameter int DEF_CLK   = 2,
    parameter int STAT_DLY  = 8,
    parameter int HOLD_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        reg_we,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hw_collapse_req,
    output logic        sw_few_en,
    output logic        sw_rest_en,
    output logic        dom_clamp,
    output logic        dom_rst,
    output logic        dom_clk_en,
    output logic        pwr_on_status,
    output logic        retain_mem,
    output logic        retain_periph
);
    logic              collapse_bit;
    logic              hw_mode;
    logic              ovr;
    logic [WAIT_W-1:0] w_rest;
    logic [WAIT_W-1:0] w_few;
    logic [WAIT_W-1:0] w_clk;
    logic              creq;
    logic              on_now;
    pds_drive_t        drive;

    pds_regs #(
        .WAIT_W   (WAIT_W),
        .DEF_REST (DEF_REST),
        .DEF_FEW  (DEF_FEW),
        .DEF_CLK  (DEF_CLK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .status_in (pwr_on_status),
        .rdata     (reg_rdata),
        .collapse  (collapse_bit),
        .hw_mode   (hw_mode),
        .bypass    (ovr),
        .w_rest    (w_rest),
        .w_few     (w_few),
        .w_clk     (w_clk),
        .ret_mem   (retain_mem),
        .ret_per   (retain_periph)
    );

    assign creq = hw_mode ? hw_collapse_req : collapse_bit;

    pds_fsm #(
        .WAIT_W    (WAIT_W),
        .HOLD_LOG2 (HOLD_LOG2)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (ref_tick),
        .collapse_req (creq),
        .bypass       (ovr),
        .w_rest       (w_rest),
        .w_few        (w_few),
        .w_clk        (w_clk),
        .drive        (drive),
        .on_now       (on_now)
    );

    pds_status_pipe #(.DLY(STAT_DLY)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_tick),
        .on_now (on_now),
        .status (pwr_on_status)
    );

    assign sw_few_en  = drive.few;
    assign sw_rest_en = drive.rest;
    assign dom_clamp  = drive.clamp;
    assign dom_rst    = drive.rst;
    assign dom_clk_en = drive.clk_en;
endmodule

// File: rtl/pds_checker.sv
module pds_checker (
    input logic clk,
    input logic rst_n,
    input logic ovr,
    input logic reg_we,
    input logic sw_few_en,
    input logic sw_rest_en,
    input logic dom_clamp,
    input logic dom_rst,
    input logic dom_clk_en,
    input logic retain_mem,
    input logic retain_periph
);
    AST_REST_NEEDS_FEW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rest_en |-> sw_few_en); // R3

    AST_CLK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clk_en |-> (sw_rest_en && !dom_clamp && !dom_rst)); // R3

    AST_CLK_AFTER_UNCLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dom_clk_en) && !ovr) |-> $past(!dom_clamp && sw_rest_en)); // R3

    AST_OPEN_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_few_en) && !ovr) |-> ($past(dom_clamp) && !sw_rest_en)); // R4

    AST_RETAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable({retain_mem, retain_periph})); // R9
endmodule

bind pwr_domain_seq pds_checker u_pds_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ovr           (ovr),
    .reg_we        (reg_we),
    .sw_few_en     (sw_few_en),
    .sw_rest_en    (sw_rest_en),
    .dom_clamp     (dom_clamp),
    .dom_rst       (dom_rst),
    .dom_clk_en    (dom_clk_en),
    .retain_mem    (retain_mem),
    .retain_periph (retain_periph)
);

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_collapse_req = 1'b1;
    logic        sw_few_en, sw_rest_en, dom_clamp, dom_rst, dom_clk_en;
    logic        pwr_on_status, retain_mem, retain_periph;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwr_domain_seq u_pwr_domain_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .ref_tick        (ref_tick),
        .reg_we          (reg_we),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .hw_collapse_req (hw_collapse_req),
        .sw_few_en       (sw_few_en),
        .sw_rest_en      (sw_rest_en),
        .dom_clamp       (dom_clamp),
        .dom_rst         (dom_rst),
        .dom_clk_en      (dom_clk_en),
        .pwr_on_status   (pwr_on_status),
        .retain_mem      (retain_mem),
        .retain_periph   (retain_periph)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int rest, input int few, input int clkd,
                                              input bit coll, input bit hw, input bit byp);
        return (32'(rest) << 20) | (32'(few) << 16) | (32'(clkd) << 12) |
               (32'(byp) << 2) | (32'(hw) << 1) | 32'(coll);
    endfunction

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    function automatic bit bad_combo();
        return (sw_rest_en && !sw_few_en) ||
               (dom_clk_en && (dom_clamp || dom_rst || !sw_rest_en)) ||
               (dom_clamp != dom_rst);
    endfunction

    function automatic logic pick(input int sel);
        case (sel)
            0:       return dom_clk_en;
            1:       return sw_few_en;
            default: return pwr_on_status;
        endcase
    endfunction

    task automatic wait_sig(input int sel, input logic val, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (pick(sel) == val) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic measure_up(input int f, input int r);
        int n_few = 0, n_rest = 0, n_hold = 0, n_stat = 0, viol = 0;
        bit fin = 1'b0;
        for (int i = 0; i < 3000 && !fin; i++) begin
            if (sw_few_en && !sw_rest_en) n_few++;
            if (sw_rest_en && dom_clamp) n_rest++;
            if (sw_rest_en && !dom_clamp && !dom_clk_en) n_hold++;
            if (dom_clk_en && !pwr_on_status) n_stat++;
            if (bad_combo()) viol++;
            if (pwr_on_status && dom_clk_en) fin = 1'b1;
            else @(negedge clk);
        end
        check("R3 few-switch phase length", n_few, 32'(1) << f);
        check("R3 rest-switch phase length", n_rest, 32'(1) << r);
        check("R3 clock hold after release", n_hold, 4);
        check("R5 status rise delay", n_stat, 8);
        check("R3 illegal output combination", viol, 0);
    endtask

    task automatic measure_down(input int c);
        int n_clk = 0, n_iso = 0, n_stat = 0, viol = 0;
        bit fin = 1'b0;
        for (int i = 0; i < 3000 && !fin; i++) begin
            if (sw_rest_en && !dom_clamp && !dom_clk_en) n_clk++;
            if (sw_rest_en && dom_clamp) n_iso++;
            if (!dom_clk_en && pwr_on_status) n_stat++;
            if (bad_combo()) viol++;
            if (!pwr_on_status && !sw_few_en) fin = 1'b1;
            else @(negedge clk);
        end
        check("R4 clock-gated phase length", n_clk, 32'(1) << c);
        check("R4 clamp phase length", n_iso, 1);
        check("R5 status fall delay", n_stat, 8);
        check("R4 illegal output combination", viol, 0);
    endtask

    task automatic run_all();
        logic [31:0] v;
        bit ok;

        // R1 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 switches off", {sw_few_en, sw_rest_en}, 2'b00);
        check("R1 clamp/reset set, clocks gated", {dom_clamp, dom_rst, dom_clk_en}, 3'b110);
        check("R1 status low", pwr_on_status, 1'b0);
        rd(1'b0, v); check("R1 control default", v, 32'h0028_2001);
        rd(1'b1, v); check("R1 retention default", v, 32'h0);

        // R2 writable mask, read-only status
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R2 writable mask", v, 32'h00FF_F007);
        @(negedge clk);
        check("R2 still off", sw_few_en, 1'b0);
        wr(1'b0, ctrl_word(2, 8, 2, 1, 0, 0));
        rd(1'b0, v); check("R2 restore", v, 32'h0028_2001);

        // R3/R4/R5 with default-like waits
        wr(1'b0, ctrl_word(2, 8, 2, 0, 0, 0));
        measure_up(8, 2);
        rd(1'b0, v); check("R2 status bit 31 when on", v[31], 1'b1);
        wr(1'b0, ctrl_word(2, 8, 2, 1, 0, 0));
        measure_down(2);
        rd(1'b0, v); check("R2 status bit 31 when off", v[31], 1'b0);

        // Random waits
        for (int it = 0; it < 6; it++) begin
            int r, f, c;
            r = int'($urandom % 4); f = int'($urandom % 4); c = int'($urandom % 4);
            wr(1'b0, ctrl_word(r, f, c, 0, 0, 0));
            measure_up(f, r);
            wr(1'b0, ctrl_word(r, f, c, 1, 0, 0));
            measure_down(c);
        end

        // R10 tick gating
        wr(1'b0, ctrl_word(1, 3, 1, 0, 0, 0));
        @(negedge clk);
        ref_tick = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 frozen in few phase", {sw_few_en, sw_rest_en}, 2'b10);
        ref_tick = 1'b1;
        wait_sig(2, 1'b1, 300, ok); check("R10 resumes to on", ok, 1'b1);
        wr(1'b0, ctrl_word(1, 3, 1, 1, 0, 0));
        measure_down(1);

        // R8 request during power-up
        wr(1'b0, ctrl_word(1, 2, 1, 0, 0, 0));
        @(negedge clk);
        wr(1'b0, ctrl_word(1, 2, 1, 1, 0, 0));
        check("R8 up sequence still running", sw_few_en, 1'b1);
        wait_sig(0, 1'b1, 200, ok); check("R8 reaches on before acting", ok, 1'b1);
        wait_sig(1, 1'b0, 200, ok); check("R8 then powers down", ok, 1'b1);
        wait_sig(2, 1'b0, 200, ok);
        wr(1'b0, ctrl_word(1, 2, 1, 0, 0, 0));
        wr(1'b0, ctrl_word(1, 2, 1, 1, 0, 0));
        wr(1'b0, ctrl_word(1, 2, 1, 0, 0, 0));
        repeat (60) @(negedge clk);
        check("R8 reversed request stays on", {dom_clk_en, pwr_on_status}, 2'b11);
        wr(1'b0, ctrl_word(1, 2, 1, 1, 0, 0));
        measure_down(1);

        // R6 hardware trigger
        hw_collapse_req = 1'b1;
        wr(1'b0, ctrl_word(1, 1, 1, 0, 1, 0));
        repeat (20) @(negedge clk);
        check("R6 sw bit ignored, hw says off", sw_few_en, 1'b0);
        hw_collapse_req = 1'b0;
        wait_sig(2, 1'b1, 200, ok); check("R6 hw request powers up", ok, 1'b1);
        wr(1'b0, ctrl_word(1, 1, 1, 1, 1, 0));
        repeat (30) @(negedge clk);
        check("R6 sw collapse ignored in hw mode", dom_clk_en, 1'b1);
        hw_collapse_req = 1'b1;
        wait_sig(1, 1'b0, 200, ok); check("R6 hw request powers down", ok, 1'b1);
        wait_sig(2, 1'b0, 200, ok);

        // R7 bypass
        wr(1'b0, ctrl_word(2, 8, 2, 0, 0, 1));
        check("R7 no change before next edge", sw_few_en, 1'b0);
        @(negedge clk);
        check("R7 bypass on pattern", {sw_few_en, sw_rest_en, dom_clamp, dom_rst, dom_clk_en}, 5'b11001);
        wr(1'b0, ctrl_word(2, 8, 2, 1, 0, 1));
        @(negedge clk);
        check("R7 bypass off pattern", {sw_few_en, sw_rest_en, dom_clamp, dom_rst, dom_clk_en}, 5'b00110);
        wr(1'b0, ctrl_word(2, 8, 2, 1, 0, 0));
        wait_sig(2, 1'b0, 100, ok);

        // R9 retention word
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); check("R9 retention readback", v, 32'h0000_6000);
        check("R9 retain outputs set", {retain_mem, retain_periph}, 2'b11);
        wr(1'b1, 32'h0000_4000);
        check("R9 mem only", {retain_mem, retain_periph}, 2'b10);
        wr(1'b0, 32'h0000_6001);
        check("R9 control write leaves retention", {retain_mem, retain_periph}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd7321));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule